// File: doc/BRIEF.md
# One-Dimensional Copy and Fill Mover

This block moves a linear run of elements from one memory address range to another, or stamps a constant pattern over a destination range without touching any source. Software sets it up through a small word-addressed configuration port. It loads a control word, two base addresses, per-direction element counts, per-direction strides and a pattern word. It then writes the go register. The engine walks the elements one at a time. A copy is a read request, a read response, a write request and a write response. A fill skips the read half.

While the transfer runs, the destination count register counts down. Software can sample it at any time. The count is held as two 16-bit halves in two registers, so a decrement that crosses a half boundary updates both halves in the same clock edge. That lets a read of high, low, high detect a torn sample. The engine ends in one of three ways: it completes and may raise done, it stops on a memory error response, or it refuses to start because the settings are inconsistent.

Top module: `dma1d_engine`

## Requirements
- R1: After reset, busy, done and err are low, no request is valid, and every register reads zero. Register indexes: 0 go (bit 0 starts), 1 control, 2 source base, 3 destination base, 4 count low, 5 count high, 6 stride, 7 pattern.
- R2: When control bits [11:9] equal 1 (copy), element i is read at source base + i·(source stride << size) and its read data is written to destination base + i·(destination stride << size). Control bits [2:0] are the size code, and wr_req_size carries that code.
- R3: When control bits [11:9] equal 3 (fill), every destination element receives the pattern register and no read request is issued.
- R4: The count low register holds bits 15:0 of the source count in [15:0] and of the destination count in [31:16]. The count high register holds bits 31:16 in the same layout. Each accepted write response lowers the 32-bit destination count by one, with any borrow reaching the high half in the same edge.
- R5: When control bits [23:21] are nonzero, done rises once the destination count reaches zero. When they are zero, done stays low. Done is cleared by the next go, and is never high while busy.
- R6: A go with a zero destination count raises done (when enabled) at the go edge and issues no request.
- R7: A read error response stops the engine, sets err with err_kind 1, and leaves both counts frozen.
- R8: A write error response stops the engine and sets err with err_kind 2.
- R9: Go with a transfer type other than 1 or 3, with a size code wider than the data port, or with copy counts that differ, sets err with err_kind 3 and issues no request.
- R10: Register writes, including go, are ignored while busy.
- R11: At most one request, read or write, is outstanding. No request is valid while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register write index |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 3 | Register read index |
| cfg_rdata | output | 32 | Register read data (combinational) |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read byte address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | DW | Read response data |
| rd_rsp_err | input | 1 | Read response error |
| wr_req_valid | output | 1 | Write request valid |
| wr_req_ready | input | 1 | Write request accepted |
| wr_req_addr | output | AW | Write byte address |
| wr_req_data | output | DW | Write data |
| wr_req_size | output | 3 | Element size code |
| wr_rsp_valid | input | 1 | Write response valid |
| wr_rsp_err | input | 1 | Write response error |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer completed |
| err | output | 1 | Transfer stopped on error |
| err_kind | output | 2 | 1 read, 2 write, 3 configuration |

## Verification
The bench drives a destination count of 0x10000 and injects a write error on the second element. A design that did not carry the borrow into the high half in the same edge would show 0x1FFFF, or a high/low pair that disagrees. Separate runs cover a zero count, each invalid setting, and a read error in the middle of a copy. A faulty engine would issue stray requests, or keep decrementing after the error. Register writes made during a fill must not alter the pattern or the count, and a broken lock would show up as wrong write data. Odd strides and byte sizes expose a stride that is not scaled by the size code.

// File: rtl/dma1d_pkg.sv
`timescale 1ns/1ps
package dma1d_pkg;
   localparam logic [2:0] IX_GO   = 3'd0;
   localparam logic [2:0] IX_CTRL = 3'd1;
   localparam logic [2:0] IX_SRC  = 3'd2;
   localparam logic [2:0] IX_DST  = 3'd3;
   localparam logic [2:0] IX_CLO  = 3'd4;
   localparam logic [2:0] IX_CHI  = 3'd5;
   localparam logic [2:0] IX_STEP = 3'd6;
   localparam logic [2:0] IX_FILL = 3'd7;

   localparam logic [2:0] MV_COPY = 3'd1;
   localparam logic [2:0] MV_FILL = 3'd3;

   localparam logic [1:0] EK_NONE  = 2'd0;
   localparam logic [1:0] EK_READ  = 2'd1;
   localparam logic [1:0] EK_WRITE = 2'd2;
   localparam logic [1:0] EK_CFG   = 2'd3;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RREQ, ST_RWAIT, ST_WREQ, ST_WWAIT
   } mover_st_e;
endpackage

// File: rtl/dma1d_regs.sv
`timescale 1ns/1ps
module dma1d_regs
   import dma1d_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lock,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_addr,
   input  logic [31:0]   cfg_wdata,
   input  logic [2:0]    cfg_raddr,
   output logic [31:0]   cfg_rdata,
   output logic          go,
   output logic [2:0]    size_o,
   output logic [2:0]    move_o,
   output logic [2:0]    dsel_o,
   output logic [AW-1:0] src_base,
   output logic [AW-1:0] dst_base,
   output logic [15:0]   src_inc,
   output logic [15:0]   dst_inc,
   output logic [DW-1:0] fill_o,
   output logic [31:0]   src_cnt,
   output logic [31:0]   dst_cnt,
   input  logic          src_dec,
   input  logic          dst_dec
);
   localparam int HALF = 16;
   localparam int NDIR = 2;

   logic [31:0] ctrl_q, src_q, dst_q, clo_q, chi_q, step_q, fill_q;
   logic        wr_ok;
   logic [NDIR-1:0] dec;
   logic [31:0] cnt_now [NDIR];
   logic [31:0] cnt_nxt [NDIR];

   assign wr_ok = cfg_we && !lock;
   assign go    = wr_ok && (cfg_addr == IX_GO) && cfg_wdata[0];
   assign dec   = {dst_dec, src_dec};

   for (genvar d = 0; d < NDIR; d++) begin : g_cnt
      assign cnt_now[d] = {chi_q[d*HALF +: HALF], clo_q[d*HALF +: HALF]};
      assign cnt_nxt[d] = cnt_now[d] - 32'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         src_q  <= '0;
         dst_q  <= '0;
         clo_q  <= '0;
         chi_q  <= '0;
         step_q <= '0;
         fill_q <= '0;
      end else begin
         if (wr_ok) begin
            case (cfg_addr)
               IX_CTRL: ctrl_q <= cfg_wdata;
               IX_SRC:  src_q  <= cfg_wdata;
               IX_DST:  dst_q  <= cfg_wdata;
               IX_CLO:  clo_q  <= cfg_wdata;
               IX_CHI:  chi_q  <= cfg_wdata;
               IX_STEP: step_q <= cfg_wdata;
               IX_FILL: fill_q <= cfg_wdata;
               default: ;
            endcase
         end
         for (int d = 0; d < NDIR; d++) begin
            if (dec[d]) begin
               clo_q[d*HALF +: HALF] <= cnt_nxt[d][HALF-1:0];
               chi_q[d*HALF +: HALF] <= cnt_nxt[d][31:HALF];
            end
         end
      end
   end

   always_comb begin
      case (cfg_raddr)
         IX_CTRL: cfg_rdata = ctrl_q;
         IX_SRC:  cfg_rdata = src_q;
         IX_DST:  cfg_rdata = dst_q;
         IX_CLO:  cfg_rdata = clo_q;
         IX_CHI:  cfg_rdata = chi_q;
         IX_STEP: cfg_rdata = step_q;
         IX_FILL: cfg_rdata = fill_q;
         default: cfg_rdata = '0;
      endcase
   end

   assign size_o   = ctrl_q[2:0];
   assign move_o   = ctrl_q[11:9];
   assign dsel_o   = ctrl_q[23:21];
   assign src_base = src_q[AW-1:0];
   assign dst_base = dst_q[AW-1:0];
   assign src_inc  = step_q[15:0];
   assign dst_inc  = step_q[31:16];
   assign fill_o   = fill_q[DW-1:0];
   assign src_cnt  = cnt_now[0];
   assign dst_cnt  = cnt_now[1];
endmodule

// File: rtl/dma1d_ptr.sv
`timescale 1ns/1ps
module dma1d_ptr #(
   parameter int AW    = 32,
   parameter int MAXSZ = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          adv,
   input  logic [15:0]   inc,
   input  logic [2:0]    size,
   output logic [AW-1:0] addr
);
   localparam int STEP_W = 16 + MAXSZ;

   logic [STEP_W-1:0] step;
   logic [AW-1:0]     step_x;
   logic [AW-1:0]     addr_q;

   assign step = STEP_W'(inc) << size;

   if (AW > STEP_W) begin : g_widen
      assign step_x = {{(AW-STEP_W){1'b0}}, step};
   end else begin : g_trim
      assign step_x = step[AW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (load) addr_q <= base;
      else if (adv)  addr_q <= addr_q + step_x;
   end

   assign addr = addr_q;
endmodule

// File: rtl/dma1d_ctl.sv
`timescale 1ns/1ps
module dma1d_ctl
   import dma1d_pkg::*;
#(
   parameter int MAXSZ = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        go,
   input  logic [2:0]  size,
   input  logic [2:0]  move,
   input  logic [2:0]  dsel,
   input  logic [31:0] src_cnt,
   input  logic [31:0] dst_cnt,
   input  logic        rd_req_ready,
   input  logic        rd_rsp_valid,
   input  logic        rd_rsp_err,
   input  logic        wr_req_ready,
   input  logic        wr_rsp_valid,
   input  logic        wr_rsp_err,
   output logic        rd_req_valid,
   output logic        wr_req_valid,
   output logic        load,
   output logic        src_step,
   output logic        dst_step,
   output logic        busy,
   output logic        done,
   output logic        err,
   output logic [1:0]  err_kind
);
   mover_st_e  st_q, st_n;
   logic       done_q, done_n, err_q, err_n;
   logic [1:0] ek_q, ek_n;
   logic       cfg_bad, is_copy;

   assign is_copy = (move == MV_COPY);
   assign cfg_bad = (!is_copy && move != MV_FILL) ||
                    (int'(size) > MAXSZ) ||
                    (is_copy && src_cnt != dst_cnt);

   always_comb begin
      st_n   = st_q;
      done_n = done_q;
      err_n  = err_q;
      ek_n   = ek_q;
      case (st_q)
         ST_IDLE: if (go) begin
            done_n = 1'b0;
            err_n  = 1'b0;
            ek_n   = EK_NONE;
            if (cfg_bad) begin
               err_n = 1'b1;
               ek_n  = EK_CFG;
            end else if (dst_cnt == 32'd0) begin
               done_n = (dsel != 3'd0);
            end else begin
               st_n = is_copy ? ST_RREQ : ST_WREQ;
            end
         end
         ST_RREQ: if (rd_req_ready) st_n = ST_RWAIT;
         ST_RWAIT: if (rd_rsp_valid) begin
            if (rd_rsp_err) begin
               err_n = 1'b1;
               ek_n  = EK_READ;
               st_n  = ST_IDLE;
            end else begin
               st_n = ST_WREQ;
            end
         end
         ST_WREQ: if (wr_req_ready) st_n = ST_WWAIT;
         ST_WWAIT: if (wr_rsp_valid) begin
            if (wr_rsp_err) begin
               err_n = 1'b1;
               ek_n  = EK_WRITE;
               st_n  = ST_IDLE;
            end else if (dst_cnt == 32'd1) begin
               done_n = (dsel != 3'd0);
               st_n   = ST_IDLE;
            end else begin
               st_n = is_copy ? ST_RREQ : ST_WREQ;
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         ek_q   <= EK_NONE;
      end else begin
         st_q   <= st_n;
         done_q <= done_n;
         err_q  <= err_n;
         ek_q   <= ek_n;
      end
   end

   assign rd_req_valid = (st_q == ST_RREQ);
   assign wr_req_valid = (st_q == ST_WREQ);
   assign load     = go && (st_q == ST_IDLE);
   assign src_step = (st_q == ST_RWAIT) && rd_rsp_valid && !rd_rsp_err;
   assign dst_step = (st_q == ST_WWAIT) && wr_rsp_valid && !wr_rsp_err;
   assign busy     = (st_q != ST_IDLE);
   assign done     = done_q;
   assign err      = err_q;
   assign err_kind = ek_q;
endmodule

// File: rtl/dma1d_engine.sv
`timescale 1ns/1ps
module dma1d_engine
   import dma1d_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_addr,
   input  logic [31:0]   cfg_wdata,
   input  logic [2:0]    cfg_raddr,
   output logic [31:0]   cfg_rdata,
   output logic          rd_req_valid,
   input  logic          rd_req_ready,
   output logic [AW-1:0] rd_req_addr,
   input  logic          rd_rsp_valid,
   input  logic [DW-1:0] rd_rsp_data,
   input  logic          rd_rsp_err,
   output logic          wr_req_valid,
   input  logic          wr_req_ready,
   output logic [AW-1:0] wr_req_addr,
   output logic [DW-1:0] wr_req_data,
   output logic [2:0]    wr_req_size,
   input  logic          wr_rsp_valid,
   input  logic          wr_rsp_err,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic [1:0]    err_kind
);
   localparam int MAXSZ = $clog2(DW / 8);

   if (DW != 8 && DW != 16 && DW != 32) begin : g_bad_dw
      $error("dma1d_engine: DW must be 8, 16 or 32");
   end
   if (AW < 16 || AW > 32) begin : g_bad_aw
      $error("dma1d_engine: AW must lie in 16..32");
   end

   logic          go, load, src_step, dst_step;
   logic [2:0]    cur_size, cur_move, cur_dsel;
   logic [AW-1:0] src_base, dst_base;
   logic [15:0]   src_inc, dst_inc;
   logic [DW-1:0] fill_w, data_q;
   logic [31:0]   src_cnt, dst_cnt;

   dma1d_regs #(.AW(AW), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .lock(busy),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .go(go),
      .size_o(cur_size), .move_o(cur_move), .dsel_o(cur_dsel),
      .src_base(src_base), .dst_base(dst_base),
      .src_inc(src_inc), .dst_inc(dst_inc), .fill_o(fill_w),
      .src_cnt(src_cnt), .dst_cnt(dst_cnt),
      .src_dec(src_step), .dst_dec(dst_step)
   );

   dma1d_ptr #(.AW(AW), .MAXSZ(MAXSZ)) u_src_ptr (
      .clk(clk), .rst_n(rst_n), .load(load), .base(src_base),
      .adv(src_step), .inc(src_inc), .size(cur_size), .addr(rd_req_addr)
   );

   dma1d_ptr #(.AW(AW), .MAXSZ(MAXSZ)) u_dst_ptr (
      .clk(clk), .rst_n(rst_n), .load(load), .base(dst_base),
      .adv(dst_step), .inc(dst_inc), .size(cur_size), .addr(wr_req_addr)
   );

   dma1d_ctl #(.MAXSZ(MAXSZ)) u_ctl (
      .clk(clk), .rst_n(rst_n), .go(go),
      .size(cur_size), .move(cur_move), .dsel(cur_dsel),
      .src_cnt(src_cnt), .dst_cnt(dst_cnt),
      .rd_req_ready(rd_req_ready), .rd_rsp_valid(rd_rsp_valid),
      .rd_rsp_err(rd_rsp_err), .wr_req_ready(wr_req_ready),
      .wr_rsp_valid(wr_rsp_valid), .wr_rsp_err(wr_rsp_err),
      .rd_req_valid(rd_req_valid), .wr_req_valid(wr_req_valid),
      .load(load), .src_step(src_step), .dst_step(dst_step),
      .busy(busy), .done(done), .err(err), .err_kind(err_kind)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        data_q <= '0;
      else if (src_step) data_q <= rd_rsp_data;
   end

   assign wr_req_data = (cur_move == MV_FILL) ? fill_w : data_q;
   assign wr_req_size = cur_size;
endmodule

// File: rtl/dma1d_chk.sv
`timescale 1ns/1ps
module dma1d_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          err,
   input logic [1:0]    err_kind,
   input logic          cfg_we,
   input logic          rd_req_valid,
   input logic          rd_req_ready,
   input logic [AW-1:0] rd_req_addr,
   input logic          wr_req_valid,
   input logic          wr_rsp_valid,
   input logic          wr_rsp_err,
   input logic [2:0]    cur_move,
   input logic [31:0]   src_cnt,
   input logic [31:0]   dst_cnt
);
   AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req_valid && wr_req_valid)); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!rd_req_valid && !wr_req_valid)); // R11
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))); // R2
   AST_FILL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cur_move == 3'd3) |-> !rd_req_valid); // R3
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_rsp_valid && !wr_rsp_err) |=> (dst_cnt == $past(dst_cnt) - 32'd1)); // R4
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !err)); // R5
   AST_ERR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !cfg_we) |=> ($stable(dst_cnt) && $stable(src_cnt))); // R7
   AST_ERR_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (err_kind != 2'd0)); // R9
endmodule

bind dma1d_engine dma1d_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
   .err_kind(err_kind), .cfg_we(cfg_we), .rd_req_valid(rd_req_valid),
   .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
   .wr_req_valid(wr_req_valid), .wr_rsp_valid(wr_rsp_valid),
   .wr_rsp_err(wr_rsp_err), .cur_move(cur_move),
   .src_cnt(src_cnt), .dst_cnt(dst_cnt)
);

// File: tb/dma1d_engine_bench.sv
`timescale 1ns/1ps
module dma1d_engine_bench;
   localparam int AW = 32;
   localparam int DW = 32;

   typedef struct packed {
      logic [2:0]  sz;
      logic [2:0]  mv;
      logic [2:0]  ds;
      logic [31:0] src;
      logic [31:0] dst;
      logic [15:0] n;
      logic [15:0] sinc;
      logic [15:0] dinc;
      logic [31:0] fill;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{3'd2, 3'd1, 3'd1, 32'h1000, 32'h8000, 16'd4, 16'd1, 16'd1, 32'h0},
      '{3'd0, 3'd1, 3'd3, 32'h2001, 32'h9003, 16'd3, 16'd2, 16'd3, 32'h0},
      '{3'd2, 3'd3, 3'd1, 32'h0,    32'hA000, 16'd5, 16'd0, 16'd1, 32'hDEADBEEF},
      '{3'd0, 3'd3, 3'd1, 32'h0,    32'hB001, 16'd3, 16'd0, 16'd4, 32'h5A5A5A5A},
      '{3'd1, 3'd1, 3'd0, 32'h3000, 32'hC000, 16'd2, 16'd1, 16'd2, 32'h0},
      '{3'd2, 3'd3, 3'd1, 32'h0,    32'hD000, 16'd0, 16'd0, 16'd1, 32'h1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [2:0]    cfg_raddr = '0;
   logic [31:0]   cfg_rdata;
   logic          rd_req_valid, wr_req_valid;
   logic          rd_req_ready = 1'b1;
   logic          wr_req_ready = 1'b1;
   logic [AW-1:0] rd_req_addr, wr_req_addr;
   logic          rd_rsp_valid = 1'b0;
   logic [DW-1:0] rd_rsp_data = '0;
   logic          rd_rsp_err = 1'b0;
   logic [DW-1:0] wr_req_data;
   logic [2:0]    wr_req_size;
   logic          wr_rsp_valid = 1'b0;
   logic          wr_rsp_err = 1'b0;
   logic          busy, done, err;
   logic [1:0]    err_kind;

   int checks = 0;
   int fails = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   int rd_err_at = -1;
   int wr_err_at = -1;
   int overlap = 0;
   logic [31:0] log_a [64];
   logic [31:0] log_d [64];
   logic [2:0]  log_s [64];

   always #2.5 clk = ~clk;

   dma1d_engine #(.AW(AW), .DW(DW)) u_dma1d_engine (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
      .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
      .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
      .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
      .wr_req_addr(wr_req_addr), .wr_req_data(wr_req_data),
      .wr_req_size(wr_req_size), .wr_rsp_valid(wr_rsp_valid),
      .wr_rsp_err(wr_rsp_err), .busy(busy), .done(done), .err(err),
      .err_kind(err_kind)
   );

   function automatic logic [31:0] mdata(input logic [31:0] a);
      return {~a[15:0], a[15:0]};
   endfunction

   // memory model: one request at a time, response one cycle after acceptance
   initial begin
      logic [31:0] a;
      logic        e;
      forever begin
         @(negedge clk);
         if (rd_req_valid && wr_req_valid) overlap++;
         if (rd_req_valid) begin
            a = rd_req_addr;
            e = (rd_cnt == rd_err_at);
            rd_cnt++;
            @(posedge clk); #1;
            rd_rsp_valid = 1'b1; rd_rsp_data = mdata(a); rd_rsp_err = e;
            @(posedge clk); #1;
            rd_rsp_valid = 1'b0; rd_rsp_err = 1'b0;
         end else if (wr_req_valid) begin
            if (wr_cnt < 64) begin
               log_a[wr_cnt] = wr_req_addr;
               log_d[wr_cnt] = wr_req_data;
               log_s[wr_cnt] = wr_req_size;
            end
            e = (wr_cnt == wr_err_at);
            wr_cnt++;
            @(posedge clk); #1;
            wr_rsp_valid = 1'b1; wr_rsp_err = e;
            @(posedge clk); #1;
            wr_rsp_valid = 1'b0; wr_rsp_err = 1'b0;
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wreg(input logic [2:0] ix, input logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = ix; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rreg(input logic [2:0] ix, output logic [31:0] v);
      cfg_raddr = ix;
      #1;
      v = cfg_rdata;
   endtask

   task automatic setup(input logic [2:0] sz, input logic [2:0] mv, input logic [2:0] ds,
                        input logic [31:0] src, input logic [31:0] dst,
                        input logic [31:0] clo, input logic [31:0] chi,
                        input logic [31:0] step, input logic [31:0] fill);
      wreg(3'd1, {8'h0, ds, 9'h0, mv, 6'h0, sz});
      wreg(3'd2, src);
      wreg(3'd3, dst);
      wreg(3'd4, clo);
      wreg(3'd5, chi);
      wreg(3'd6, step);
      wreg(3'd7, fill);
      rd_cnt = 0; wr_cnt = 0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v, h1, h2, ea, ed;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1", "busy", {31'h0, busy}, 32'h0);
      chk("R1", "done", {31'h0, done}, 32'h0);
      chk("R1", "err", {31'h0, err}, 32'h0);
      chk("R1", "requests", {30'h0, rd_req_valid, wr_req_valid}, 32'h0);
      rreg(3'd1, v); chk("R1", "control reg", v, 32'h0);
      rreg(3'd4, v); chk("R1", "count low reg", v, 32'h0);

      // vector table walk: R2 copy, R3 fill, R5 done select, R6 zero count
      for (int vi = 0; vi < NV; vi++) begin
         vec_t t;
         string rq;
         t = VECS[vi];
         rq = (t.mv == 3'd3) ? "R3" : "R2";
         setup(t.sz, t.mv, t.ds, t.src, t.dst, {t.n, t.n}, 32'h0,
               {t.dinc, t.sinc}, t.fill);
         wreg(3'd0, 32'h1);
         wait_idle();
         chk("R5", "done after transfer", {31'h0, done}, {31'h0, (t.ds != 3'd0)});
         chk(rq, "write count", 32'(wr_cnt), 32'(t.n));
         chk(rq, "read count", 32'(rd_cnt), (t.mv == 3'd1) ? 32'(t.n) : 32'h0);
         if (t.n == 16'd0) chk("R6", "no requests on zero count", 32'(rd_cnt + wr_cnt), 32'h0);
         for (int i = 0; i < int'(t.n); i++) begin
            ea = t.dst + 32'(i) * (32'(t.dinc) << t.sz);
            ed = (t.mv == 3'd3) ? t.fill : mdata(t.src + 32'(i) * (32'(t.sinc) << t.sz));
            chk(rq, "write address", log_a[i], ea);
            chk(rq, "write data", log_d[i], ed);
            chk("R2", "write size", {29'h0, log_s[i]}, {29'h0, t.sz});
         end
         rreg(3'd4, v);
         chk("R4", "dst count after finish", {16'h0, v[31:16]}, 32'h0);
      end

      // R9 config errors; R5 done cleared by go
      setup(3'd2, 3'd2, 3'd1, 32'h0, 32'h100, 32'h00020002, 32'h0, 32'h00010001, 32'h0);
      wreg(3'd0, 32'h1);
      wait_idle();
      chk("R5", "done cleared by go", {31'h0, done}, 32'h0);
      chk("R9", "wrap type err_kind", {29'h0, err, err_kind}, 32'h7);
      chk("R9", "wrap type no requests", 32'(rd_cnt + wr_cnt), 32'h0);
      setup(3'd3, 3'd1, 3'd1, 32'h0, 32'h100, 32'h00020002, 32'h0, 32'h00010001, 32'h0);
      wreg(3'd0, 32'h1);
      wait_idle();
      chk("R9", "oversize err_kind", {29'h0, err, err_kind}, 32'h7);
      chk("R9", "oversize no requests", 32'(rd_cnt + wr_cnt), 32'h0);
      setup(3'd2, 3'd1, 3'd1, 32'h0, 32'h100, 32'h00030002, 32'h0, 32'h00010001, 32'h0);
      wreg(3'd0, 32'h1);
      wait_idle();
      chk("R9", "count mismatch err_kind", {29'h0, err, err_kind}, 32'h7);
      chk("R9", "count mismatch no requests", 32'(rd_cnt + wr_cnt), 32'h0);

      // R7 read error mid copy
      setup(3'd2, 3'd1, 3'd1, 32'h1000, 32'h8000, 32'h00040004, 32'h0, 32'h00010001, 32'h0);
      rd_err_at = 1;
      wreg(3'd0, 32'h1);
      wait_idle();
      rd_err_at = -1;
      chk("R7", "read err_kind", {29'h0, err, err_kind}, 32'h5);
      chk("R7", "reads issued", 32'(rd_cnt), 32'h2);
      chk("R7", "writes issued", 32'(wr_cnt), 32'h1);
      rreg(3'd4, v);
      chk("R7", "counts frozen", v, 32'h00030003);
      repeat (3) @(negedge clk);
      rreg(3'd4, v);
      chk("R7", "counts still frozen", v, 32'h00030003);

      // R8 write error with R4 borrow across halves
      setup(3'd2, 3'd3, 3'd1, 32'h0, 32'hE000, 32'h0, 32'h00010000, 32'h00010000, 32'h12345678);
      wr_err_at = 1;
      wreg(3'd0, 32'h1);
      wait_idle();
      wr_err_at = -1;
      chk("R8", "write err_kind", {29'h0, err, err_kind}, 32'h6);
      chk("R8", "writes issued", 32'(wr_cnt), 32'h2);
      rreg(3'd5, h1); rreg(3'd4, v); rreg(3'd5, h2);
      chk("R4", "high half stable across reads", h1, h2);
      chk("R4", "borrow low half", {16'h0, v[31:16]}, 32'h0000FFFF);
      chk("R4", "borrow high half", {16'h0, h1[31:16]}, 32'h0);

      // R10 writes ignored while busy
      setup(3'd2, 3'd3, 3'd1, 32'h0, 32'hF000, 32'h00050000, 32'h0, 32'h00010000, 32'hCAFEF00D);
      wreg(3'd0, 32'h1);
      wreg(3'd4, 32'h00770077);
      wreg(3'd7, 32'h11111111);
      wait_idle();
      chk("R10", "writes during busy", 32'(wr_cnt), 32'h5);
      chk("R10", "last data unchanged", log_d[4], 32'hCAFEF00D);
      rreg(3'd7, v);
      chk("R10", "pattern reg unchanged", v, 32'hCAFEF00D);
      rreg(3'd4, v);
      chk("R10", "count reg ran to zero", v, 32'h0);

      chk("R11", "overlapping requests", 32'(overlap), 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule